// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the in-flight instructions of an out-of-order core in the order they were issued. Each issued instruction takes the next free slot, and the slot index goes back to the issuer as the tag under which the result will later appear. Execution units broadcast finished results on a completion bus. The matching slot captures the value, marks itself ready, and from then on forwards the value to any later instruction that looks up the tag.

Retirement happens at the oldest slot only, one instruction per cycle, and only once that slot is ready. A register operation retires by writing the register file. A store retires by writing memory. A branch writes nothing. If a retiring branch was mispredicted, or the retiring instruction recorded an exception, every younger slot is discarded in the same cycle. Exceptions are therefore reported only at retirement and are precise. A side query tells the load path whether any store still held in the buffer targets a given address, so that the load can be held back.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `issue_ready`=1, `issue_tag`=0, and `commit_valid`, `flush`, `exc_valid` and `ld_block` are all 0.
- R2: An accepted issue (`issue_valid` and `issue_ready` both high) takes the slot named by `issue_tag`, and tags advance by one modulo 8 in issue order. When 8 slots are occupied, `issue_ready` is 0 and an issue request is ignored: no ninth entry ever retires.
- R3: A completion (`cmpl_valid`) whose tag names an occupied slot stores `cmpl_value` into that slot and marks it ready. A completion for an unoccupied slot has no effect.
- R4: `look_ready` is 1 when the looked-up slot is occupied and ready, and `look_value` then returns its stored value. A completion to the same tag in the same cycle is forwarded at once.
- R5: `commit_valid` is high only while the oldest slot is ready, so slots retire strictly in issue order. A ready younger slot waits behind an unready older one.
- R6: On retirement, instruction kind 0 (register op) drives `reg_we`=1 and kind 1 (store) drives `mem_we`=1, each with `commit_dest` and `commit_value` taken from the slot. Kind 2 (branch) drives neither strobe.
- R7: A retiring branch completed with `cmpl_mispredict`=1 raises `flush` in its retirement cycle, during which `issue_ready` is 0. On the next cycle the buffer is empty and `issue_tag` equals the branch tag plus one. A correctly predicted branch raises no flush.
- R8: A completion with `cmpl_exc`=1 is reported only when its slot retires. At that point `exc_valid` and `flush` are 1, both write strobes are 0, and all younger slots are discarded.
- R9: `ld_block` is 1 exactly when some occupied slot of kind store has a destination equal to `ld_addr`. It falls once that store has retired.
- R10: A completion for a tag discarded by a flush is ignored: the tag does not become ready.
- R11: An issue and a retirement in the same cycle are both accepted, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Request to allocate a slot |
| issue_kind | input | 2 | 0 register op, 1 store, 2 branch |
| issue_dest | input | DEST_W | Register number or store address |
| issue_ready | output | 1 | A slot is free and no flush is under way |
| issue_tag | output | TAG_W | Tag of the slot the issue takes |
| cmpl_valid | input | 1 | Completion broadcast present |
| cmpl_tag | input | TAG_W | Tag being completed |
| cmpl_value | input | DATA_W | Result value, or store data |
| cmpl_exc | input | 1 | Instruction raised an exception |
| cmpl_mispredict | input | 1 | Branch was mispredicted |
| look_tag | input | TAG_W | Tag of the operand lookup |
| look_ready | output | 1 | Looked-up value available |
| look_value | output | DATA_W | Forwarded operand |
| ld_addr | input | DEST_W | Address of a pending load |
| ld_block | output | 1 | An older store to that address is buffered |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring slot |
| commit_dest | output | DEST_W | Destination of the retiring slot |
| commit_value | output | DATA_W | Value of the retiring slot |
| reg_we | output | 1 | Register file write strobe |
| mem_we | output | 1 | Memory write strobe |
| flush | output | 1 | Younger slots discarded this cycle |
| exc_valid | output | 1 | Precise exception at retirement |

## Verification
The assertions assume that each tag is completed at most once while its slot is occupied, that every completed tag was handed out earlier, and that the mispredict flag is raised only for branches. The bench completes each occupied tag exactly once. It sends the single deliberately stale completion only after a flush has emptied the buffer, and it never reissues that tag before the stale completion has passed. It raises the mispredict flag only on a branch slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flushAll;
  } rob_strobe_t;
endpackage

// File: rtl/rob_datapath.sv
module rob_datapath
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 3,
  parameter int DEST_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rob_strobe_t       strobe,
  input  logic [TAG_W-1:0]  allocIdx,
  input  logic [TAG_W-1:0]  headIdx,
  input  kind_e             allocKind,
  input  logic [DEST_W-1:0] allocDest,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplValue,
  input  logic              cmplExc,
  input  logic              cmplMisp,
  input  logic [TAG_W-1:0]  lookTag,
  output logic              lookReady,
  output logic [DATA_W-1:0] lookValue,
  input  logic [DEST_W-1:0] ldAddr,
  output logic              ldBlock,
  output logic              headValid,
  output logic              headReady,
  output kind_e             headKind,
  output logic [DEST_W-1:0] headDest,
  output logic [DATA_W-1:0] headValue,
  output logic              headExc,
  output logic              headMisp
);
  logic              entValid [DEPTH];
  logic              entReady [DEPTH];
  kind_e             entKind  [DEPTH];
  logic [DEST_W-1:0] entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];
  logic              entExc   [DEPTH];
  logic              entMisp  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic cmplHit;
    logic allocHit;
    logic retireHit;
    assign cmplHit   = cmplValid && (cmplTag == TAG_W'(i)) && entValid[i];
    assign allocHit  = strobe.alloc && (allocIdx == TAG_W'(i));
    assign retireHit = strobe.retire && (headIdx == TAG_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entValid[i] <= 1'b0;
        entReady[i] <= 1'b0;
        entKind[i]  <= KIND_REG;
        entDest[i]  <= '0;
        entValue[i] <= '0;
        entExc[i]   <= 1'b0;
        entMisp[i]  <= 1'b0;
      end else if (strobe.flushAll) begin
        entValid[i] <= 1'b0;
        entReady[i] <= 1'b0;
      end else begin
        if (retireHit) entValid[i] <= 1'b0;
        if (allocHit) begin
          entValid[i] <= 1'b1;
          entReady[i] <= 1'b0;
          entKind[i]  <= allocKind;
          entDest[i]  <= allocDest;
          entExc[i]   <= 1'b0;
          entMisp[i]  <= 1'b0;
        end else if (cmplHit) begin
          entReady[i] <= 1'b1;
          entValue[i] <= cmplValue;
          entExc[i]   <= cmplExc;
          entMisp[i]  <= cmplMisp;
        end
      end
    end
  end

  // operand forwarding with same-cycle bypass
  logic lookBypass;
  assign lookBypass = cmplValid && (cmplTag == lookTag);
  assign lookReady  = entValid[lookTag] && (entReady[lookTag] || lookBypass);
  assign lookValue  = lookBypass ? cmplValue : entValue[lookTag];

  // store address match against the load query
  always_comb begin
    ldBlock = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (entValid[i] && entKind[i] == KIND_STORE && entDest[i] == ldAddr)
        ldBlock = 1'b1;
  end

  assign headValid = entValid[headIdx];
  assign headReady = entReady[headIdx];
  assign headKind  = entKind[headIdx];
  assign headDest  = entDest[headIdx];
  assign headValue = entValue[headIdx];
  assign headExc   = entExc[headIdx];
  assign headMisp  = entMisp[headIdx];

  // R3: a completion to a live slot leaves it ready
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmplValid && entValid[cmplTag] && !strobe.flushAll &&
     !(strobe.retire && headIdx == cmplTag))
    |=> entReady[$past(cmplTag)]);

  // R10: a completion to an empty slot does not bring it to life
  p_stale_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmplValid && !entValid[cmplTag] && !(strobe.alloc && allocIdx == cmplTag))
    |=> !entValid[$past(cmplTag)]);
endmodule

// File: rtl/rob_control.sv
module rob_control
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  output logic             issueReady,
  output logic [TAG_W-1:0] issueTag,
  input  logic             headValid,
  input  logic             headReady,
  input  kind_e            headKind,
  input  logic             headExc,
  input  logic             headMisp,
  output rob_strobe_t      strobe,
  output logic [TAG_W-1:0] headIdx,
  output logic             commitValid,
  output logic             regWe,
  output logic             memWe,
  output logic             flush,
  output logic             excValid
);
  localparam int CNT_W = TAG_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [TAG_W-1:0] headPtr;
  logic [TAG_W-1:0] tailPtr;
  logic [CNT_W-1:0] count;

  logic commitNow;
  logic flushNow;

  assign commitNow = headValid && headReady;
  assign flushNow  = commitNow && (headExc || (headKind == KIND_BRANCH && headMisp));

  assign commitValid = commitNow;
  assign flush       = flushNow;
  assign excValid    = commitNow && headExc;
  assign regWe       = commitNow && !headExc && headKind == KIND_REG;
  assign memWe       = commitNow && !headExc && headKind == KIND_STORE;

  assign issueReady = (count != FULL_CNT) && !flushNow;
  assign issueTag   = tailPtr;
  assign headIdx    = headPtr;

  assign strobe.alloc    = issueValid && issueReady;
  assign strobe.retire   = commitNow;
  assign strobe.flushAll = flushNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (flushNow) begin
      headPtr <= headPtr + 1'b1;
      tailPtr <= headPtr + 1'b1;
      count   <= '0;
    end else begin
      if (strobe.retire) headPtr <= headPtr + 1'b1;
      if (strobe.alloc)  tailPtr <= tailPtr + 1'b1;
      count <= count + CNT_W'(strobe.alloc) - CNT_W'(strobe.retire);
    end
  end

  // R2: occupancy never exceeds the slot count
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && !commitNow) |=> count == FULL_CNT);

  // R5: each retirement moves the oldest pointer by exactly one
  p_inorder_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commitNow |=> headPtr == $past(headPtr) + 1'b1);

  // R7: a flush leaves an empty buffer behind
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flushNow |=> (count == '0 && headPtr == tailPtr));

  // R8: an exception blocks architectural writes
  p_exc_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (!regWe && !memWe && flushNow));

  // R11: issue plus retirement keeps occupancy
  p_issue_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.alloc && commitNow && !flushNow) |=> count == $past(count));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEST_W = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        issue_kind,
  input  logic [DEST_W-1:0] issue_dest,
  output logic              issue_ready,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic              cmpl_exc,
  input  logic              cmpl_mispredict,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_ready,
  output logic [DATA_W-1:0] look_value,
  input  logic [DEST_W-1:0] ld_addr,
  output logic              ld_block,
  output logic              commit_valid,
  output logic [TAG_W-1:0]  commit_tag,
  output logic [DEST_W-1:0] commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              reg_we,
  output logic              mem_we,
  output logic              flush,
  output logic              exc_valid
);
  rob_strobe_t      strobe;
  logic [TAG_W-1:0] headIdx;
  logic             headValid, headReady, headExc, headMisp;
  kind_e            headKind;

  rob_control #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issue_valid), .issueReady(issue_ready), .issueTag(issue_tag),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headExc(headExc), .headMisp(headMisp),
    .strobe(strobe), .headIdx(headIdx),
    .commitValid(commit_valid), .regWe(reg_we), .memWe(mem_we),
    .flush(flush), .excValid(exc_valid)
  );

  rob_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocIdx(issue_tag), .headIdx(headIdx),
    .allocKind(kind_e'(issue_kind)), .allocDest(issue_dest),
    .cmplValid(cmpl_valid), .cmplTag(cmpl_tag), .cmplValue(cmpl_value),
    .cmplExc(cmpl_exc), .cmplMisp(cmpl_mispredict),
    .lookTag(look_tag), .lookReady(look_ready), .lookValue(look_value),
    .ldAddr(ld_addr), .ldBlock(ld_block),
    .headValid(headValid), .headReady(headReady), .headKind(headKind),
    .headDest(commit_dest), .headValue(commit_value),
    .headExc(headExc), .headMisp(headMisp)
  );

  assign commit_tag = headIdx;
endmodule

// File: tb/spec_rob_test.sv
module spec_rob_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_OPS = 6;
  localparam logic [1:0]  OP_KIND  [N_OPS] = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0};
  localparam logic [15:0] OP_DEST  [N_OPS] = '{16'd3, 16'h0040, 16'd7, 16'd0, 16'h0080, 16'd9};
  localparam logic [31:0] OP_VALUE [N_OPS] = '{32'h1111, 32'h2222, 32'h3333, 32'h4444, 32'h5555, 32'h6666};

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0; logic [1:0] issue_kind = 0; logic [15:0] issue_dest = 0;
  logic issue_ready; logic [2:0] issue_tag;
  logic cmpl_valid = 0; logic [2:0] cmpl_tag = 0; logic [31:0] cmpl_value = 0;
  logic cmpl_exc = 0, cmpl_mispredict = 0;
  logic [2:0] look_tag = 0; logic look_ready; logic [31:0] look_value;
  logic [15:0] ld_addr = 16'hffff; logic ld_block;
  logic commit_valid; logic [2:0] commit_tag; logic [15:0] commit_dest; logic [31:0] commit_value;
  logic reg_we, mem_we, flush, exc_valid;

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_rob uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stepc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    issue_valid = 0; cmpl_valid = 0; cmpl_exc = 0; cmpl_mispredict = 0;
  endtask

  task automatic doIssue(input logic [1:0] k, input logic [15:0] d);
    issue_valid = 1; issue_kind = k; issue_dest = d;
  endtask

  task automatic doCmpl(input logic [2:0] t, input logic [31:0] v, input logic e, input logic m);
    cmpl_valid = 1; cmpl_tag = t; cmpl_value = v; cmpl_exc = e; cmpl_mispredict = m;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 issue_ready", 32'(issue_ready), 1);
    check("R1 issue_tag", 32'(issue_tag), 0);
    check("R1 commit_valid", 32'(commit_valid), 0);
    check("R1 flush/exc", 32'({flush, exc_valid, ld_block}), 0);

    // table walk: issue all ops in order (R2)
    for (int i = 0; i < N_OPS; i++) begin
      doIssue(OP_KIND[i], OP_DEST[i]); #1;
      check("R2 tag order", 32'(issue_tag), 32'(i));
      stepc();
    end
    idle();
    // complete youngest first; oldest not ready so nothing retires (R5)
    for (int j = N_OPS - 1; j >= 1; j--) begin
      doCmpl(3'(j), OP_VALUE[j], 0, 0);
      look_tag = 3'(j); #1;
      check("R5 no early commit", 32'(commit_valid), 0);
      check("R4 bypass ready", 32'(look_ready), 1);
      check("R4 bypass value", look_value, OP_VALUE[j]);
      stepc();
    end
    doCmpl(3'd0, OP_VALUE[0], 0, 0);
    look_tag = 3'd5; ld_addr = OP_DEST[1]; #1;
    check("R4 stored value", look_value, OP_VALUE[5]);
    check("R9 store match", 32'(ld_block), 1);
    check("R5 head still pending", 32'(commit_valid), 0);
    ld_addr = 16'h0041; #1;
    check("R9 no match", 32'(ld_block), 0);
    stepc(); idle();
    // retire in order (R6)
    for (int k = 0; k < N_OPS; k++) begin
      ld_addr = OP_DEST[1]; #1;
      check("R6 commit_valid", 32'(commit_valid), 1);
      check("R6 commit_tag", 32'(commit_tag), 32'(k));
      check("R6 reg_we", 32'(reg_we), 32'(OP_KIND[k] == 2'd0));
      check("R6 mem_we", 32'(mem_we), 32'(OP_KIND[k] == 2'd1));
      check("R7 no flush on good branch", 32'(flush), 0);
      check("R9 block until store retires", 32'(ld_block), 32'(k <= 1));
      if (OP_KIND[k] != 2'd2) begin
        check("R6 commit_value", commit_value, OP_VALUE[k]);
        check("R6 commit_dest", 32'(commit_dest), 32'(OP_DEST[k]));
      end
      stepc();
    end
    #1;
    check("R5 drained", 32'(commit_valid), 0);

    // fill to capacity (R2), tags start at 6
    for (int n = 0; n < 8; n++) begin
      doIssue(2'd0, 16'(n)); #1;
      check("R2 wrap tag", 32'(issue_tag), 32'((6 + n) % 8));
      stepc();
    end
    #1;
    check("R2 full", 32'(issue_ready), 0);
    stepc(); idle();
    for (int n = 7; n >= 0; n--) begin
      doCmpl(3'((6 + n) % 8), 32'h300 + 32'(n), 0, 0);
      stepc();
    end
    idle();
    for (int n = 0; n < 8; n++) begin
      #1;
      check("R2 drain tag", 32'(commit_tag), 32'((6 + n) % 8));
      check("R2 drain value", commit_value, 32'h300 + 32'(n));
      stepc();
    end
    #1;
    check("R2 request while full ignored", 32'(commit_valid), 0);

    // mispredicted branch (R7)
    doIssue(2'd2, 16'd0); stepc();
    doIssue(2'd0, 16'd1); stepc();
    doIssue(2'd0, 16'd2); stepc(); idle();
    doCmpl(3'd7, 32'h77, 0, 0); stepc();
    doCmpl(3'd0, 32'h88, 0, 0); stepc();
    doCmpl(3'd6, 32'h0, 0, 1); stepc(); idle(); #1;
    check("R7 flush", 32'(flush), 1);
    check("R7 branch tag", 32'(commit_tag), 6);
    check("R7 no write", 32'({reg_we, mem_we}), 0);
    check("R7 issue held", 32'(issue_ready), 0);
    stepc(); #1;
    check("R7 empty after", 32'(commit_valid), 0);
    check("R7 tail after flush", 32'(issue_tag), 7);
    // stale completion for a discarded tag (R10)
    doCmpl(3'd0, 32'hdead, 0, 0); look_tag = 3'd0; #1;
    check("R10 stale bypass", 32'(look_ready), 0);
    stepc(); idle(); #1;
    check("R10 stale ignored", 32'(look_ready), 0);
    check("R10 no commit", 32'(commit_valid), 0);

    // deferred exception (R8)
    doIssue(2'd0, 16'd4); stepc();
    doIssue(2'd0, 16'd5); stepc(); idle();
    doCmpl(3'd0, 32'h99, 0, 0); stepc();
    idle(); #1;
    check("R8 not yet raised", 32'(exc_valid), 0);
    doCmpl(3'd7, 32'hbad, 1, 0); stepc(); idle(); #1;
    check("R8 exc at commit", 32'(exc_valid), 1);
    check("R8 flush", 32'(flush), 1);
    check("R8 no write", 32'({reg_we, mem_we}), 0);
    check("R8 tag", 32'(commit_tag), 7);
    stepc(); #1;
    check("R8 younger gone", 32'(commit_valid), 0);
    check("R8 tail", 32'(issue_tag), 0);

    // issue and retire together (R11)
    doIssue(2'd0, 16'd6); stepc(); idle();
    doCmpl(3'd0, 32'h55, 0, 0); stepc(); idle();
    doIssue(2'd0, 16'd8); #1;
    check("R11 issue ready", 32'(issue_ready), 1);
    check("R11 commit same cycle", 32'(commit_valid), 1);
    check("R11 issue tag", 32'(issue_tag), 1);
    stepc(); idle(); #1;
    check("R11 next tag", 32'(issue_tag), 2);
    check("R11 younger waits", 32'(commit_valid), 0);
    doCmpl(3'd1, 32'h66, 0, 0); stepc(); idle(); #1;
    check("R11 second commit", 32'(commit_tag), 1);
    check("R11 second value", commit_value, 32'h66);
    check("R11 second dest", 32'(commit_dest), 8);
    stepc(); #1;
    check("R11 empty", 32'(commit_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule